// File: doc/BRIEF.md
# Sample Slot Pending and Overrun Tracker

This block keeps the bookkeeping for a bank of conversion sample slots. Each slot can be armed by a software mask write or by its own hardware trigger pulse; an armed slot is shown as pending until a conversion-complete event for that slot arrives, or until software withdraws it with a cancel mask. Re-arming a slot that is still pending is recorded as a trigger overrun.

Every slot holds its latest result together with a valid flag and a data-overrun flag, packed into one data word. The lowest slots can be switched into a two-deep mode in which a second result register absorbs one more conversion before overrun is declared. Sticky OR-reduced summary bits and a busy bit let a controller see the state of the whole bank at a glance. Which slot converts next is decided outside this block.

Top module: `slot_tracker`

## Requirements
- R1: A software trigger write sets the pending bit of every slot whose mask bit is 1, and a hardware trigger pulse sets its slot's pending bit; both take effect on the next clock edge, and a trigger wins over a cancel of the same slot in the same cycle.
- R2: A conversion-complete event for slot s clears pending[s] on the next edge; an event whose slot index is NUM_SLOTS or above changes no state.
- R3: A cancel write clears the pending bit of every slot selected in its mask and stores no result.
- R4: Each slot's data word is RES_W+2 bits: bits RES_W-1..0 hold the last stored result, bit RES_W the data-overrun flag and bit RES_W+1 the valid flag; a conversion-complete event stores its data and sets valid.
- R5: An acknowledge of slot s clears that slot's valid flag, data-overrun flag and second-register valid flag.
- R6: In single-register operation, a result stored while the slot's valid flag is 1 sets the data-overrun flag and replaces the data.
- R7: A trigger for a slot that is already pending sets that slot's trigger-overrun flag; a clear write with a 1 in the slot's mask bit clears it, and a new overrun in the same cycle wins over the clear.
- R8: any_valid, any_dovr and any_tovr are 1 exactly while at least one slot's valid, data-overrun or trigger-overrun flag, respectively, is 1.
- R9: busy is 1 exactly while at least one slot is pending; after reset nothing is pending and every flag and result is 0.
- R10: For slots below NUM_DBUF with dbuf_en set, a result goes to the primary register if it is not valid, otherwise to the second register if that is not valid (second word: bit RES_W valid, bits RES_W-1..0 data); with both holding unread data, the result overwrites the second register and sets the data-overrun flag, leaving the primary unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_trig_we | input | 1 | Software trigger write strobe |
| sw_trig_mask | input | NUM_SLOTS | Slots armed by the software write |
| hw_trig | input | NUM_SLOTS | Per-slot hardware trigger pulses |
| cancel_we | input | 1 | Cancel write strobe |
| cancel_mask | input | NUM_SLOTS | Slots whose pending bit is withdrawn |
| eoc_valid | input | 1 | Conversion-complete event |
| eoc_slot | input | clog2(NUM_SLOTS) | Slot index of the event |
| eoc_data | input | RES_W | Conversion result |
| ack_valid | input | 1 | Result acknowledge strobe |
| ack_slot | input | clog2(NUM_SLOTS) | Slot being acknowledged |
| dbuf_en | input | NUM_DBUF | Two-deep mode enable for the lowest slots |
| tovf_clr_we | input | 1 | Trigger-overrun clear strobe |
| tovf_clr_mask | input | NUM_SLOTS | Write-1-to-clear mask for trigger overrun |
| pending | output | NUM_SLOTS | Pending vector |
| trig_ovf | output | NUM_SLOTS | Trigger-overrun flags |
| slot_word | output | NUM_SLOTS*(RES_W+2) | Data words, slot s at bits s*(RES_W+2) upward |
| dbuf_word | output | NUM_DBUF*(RES_W+1) | Second-register words, slot s at bits s*(RES_W+1) upward |
| busy | output | 1 | Any slot pending |
| any_valid | output | 1 | Any slot valid |
| any_dovr | output | 1 | Any slot data overrun |
| any_tovr | output | 1 | Any slot trigger overrun |

## Verification
The bench builds the block with its defaults: nineteen slots, sixteen-bit results and four two-deep slots. That reaches the top slot 18, a five-bit slot index whose value 25 points past the bank, and both kinds of slot side by side, so slot 0 with its two-deep mode off can be compared against slot 1 with it on. Collisions of trigger with cancel and of overrun with clear in one cycle are driven on purpose.

// File: rtl/slot_tracker_pkg.sv
package slot_tracker_pkg;

   // index width for a count of items, never below one bit
   function automatic int idx_w(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

   // flag offsets above the result field inside a data word
   localparam int OVR_OFS = 0;
   localparam int VAL_OFS = 1;

endpackage

// File: rtl/slot_pend.sv
module slot_pend #(
   parameter int NUM_SLOTS = 19
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_SLOTS-1:0] trig,
   input  logic                 cancel_we,
   input  logic [NUM_SLOTS-1:0] cancel_mask,
   input  logic [NUM_SLOTS-1:0] done_hit,
   input  logic                 clr_we,
   input  logic [NUM_SLOTS-1:0] clr_mask,
   output logic [NUM_SLOTS-1:0] pend_q,
   output logic [NUM_SLOTS-1:0] tovf_q
);

   logic [NUM_SLOTS-1:0] cancel_v;
   logic [NUM_SLOTS-1:0] clr_v;

   assign cancel_v = cancel_we ? cancel_mask : '0;
   assign clr_v    = clr_we ? clr_mask : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         tovf_q <= '0;
      end else begin
         pend_q <= (pend_q & ~cancel_v & ~done_hit) | trig;
         tovf_q <= (tovf_q & ~clr_v) | (trig & pend_q);
      end
   end

   AST_TRIG_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      (|trig) |=> ((pend_q & $past(trig)) == $past(trig))); // R1

   AST_DONE_CLEARS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      (|(done_hit & ~trig)) |=> ((pend_q & $past(done_hit & ~trig)) == '0)); // R2

   AST_CANCEL_CLEARS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      (cancel_we && |(cancel_mask & ~trig)) |=> ((pend_q & $past(cancel_mask & ~trig)) == '0)); // R3

   AST_RETRIG_FLAGS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
      (|(trig & pend_q)) |=> ((tovf_q & $past(trig & pend_q)) == $past(trig & pend_q))); // R7

endmodule

// File: rtl/slot_result.sv
module slot_result #(
   parameter int RES_W      = 16,
   parameter bit HAS_SECOND = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [RES_W-1:0] wr_data,
   input  logic             ack,
   input  logic             dben,
   output logic [RES_W+1:0] word_o,
   output logic [RES_W:0]   sec_o
);
   import slot_tracker_pkg::*;

   logic             valid_q;
   logic             ovr_q;
   logic [RES_W-1:0] data_q;
   logic             v_live;
   logic             o_live;

   // acknowledge is applied before a same-cycle store
   assign v_live = valid_q & ~ack;
   assign o_live = ovr_q & ~ack;

   assign word_o[RES_W-1:0]       = data_q;
   assign word_o[RES_W + OVR_OFS] = ovr_q;
   assign word_o[RES_W + VAL_OFS] = valid_q;

   generate
      if (HAS_SECOND) begin : g_two_deep
         logic             sval_q;
         logic [RES_W-1:0] sdat_q;
         logic             s_live;
         logic             to_primary;

         assign s_live     = sval_q & ~ack;
         assign to_primary = !dben || !v_live;
         assign sec_o      = {sval_q, sdat_q};

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               valid_q <= 1'b0;
               ovr_q   <= 1'b0;
               data_q  <= '0;
               sval_q  <= 1'b0;
               sdat_q  <= '0;
            end else begin
               valid_q <= v_live | wr;
               sval_q  <= s_live | (wr & !to_primary);
               ovr_q   <= o_live | (wr & v_live & (!dben || s_live));
               if (wr && to_primary) data_q <= wr_data;
               if (wr && !to_primary) sdat_q <= wr_data;
            end
         end

         AST_TWO_DEEP_FULL_BEFORE_OVR: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(ovr_q) && $past(dben)) |-> $past(sval_q)); // R10
      end else begin : g_one_deep
         logic unused_dben;
         assign unused_dben = dben;
         assign sec_o       = '0;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               valid_q <= 1'b0;
               ovr_q   <= 1'b0;
               data_q  <= '0;
            end else begin
               valid_q <= v_live | wr;
               ovr_q   <= o_live | (wr & v_live);
               if (wr) data_q <= wr_data;
            end
         end
      end
   endgenerate

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_q) |-> $past(valid_q)); // R6

   AST_ACK_DROPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !wr) |=> (!valid_q && !ovr_q)); // R5

endmodule

// File: rtl/slot_tracker.sv
module slot_tracker #(
   parameter int NUM_SLOTS = 19,
   parameter int RES_W     = 16,
   parameter int NUM_DBUF  = 4,
   localparam int SLW      = slot_tracker_pkg::idx_w(NUM_SLOTS),
   localparam int WW       = RES_W + 2,
   localparam int SW2      = RES_W + 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      sw_trig_we,
   input  logic [NUM_SLOTS-1:0]      sw_trig_mask,
   input  logic [NUM_SLOTS-1:0]      hw_trig,
   input  logic                      cancel_we,
   input  logic [NUM_SLOTS-1:0]      cancel_mask,
   input  logic                      eoc_valid,
   input  logic [SLW-1:0]            eoc_slot,
   input  logic [RES_W-1:0]          eoc_data,
   input  logic                      ack_valid,
   input  logic [SLW-1:0]            ack_slot,
   input  logic [NUM_DBUF-1:0]       dbuf_en,
   input  logic                      tovf_clr_we,
   input  logic [NUM_SLOTS-1:0]      tovf_clr_mask,
   output logic [NUM_SLOTS-1:0]      pending,
   output logic [NUM_SLOTS-1:0]      trig_ovf,
   output logic [NUM_SLOTS*WW-1:0]   slot_word,
   output logic [NUM_DBUF*SW2-1:0]   dbuf_word,
   output logic                      busy,
   output logic                      any_valid,
   output logic                      any_dovr,
   output logic                      any_tovr
);
   import slot_tracker_pkg::*;

   generate
      if (NUM_DBUF < 1 || NUM_DBUF > NUM_SLOTS) begin : g_bad_dbuf
         $error("slot_tracker: NUM_DBUF must lie in 1..NUM_SLOTS");
      end
      if (RES_W < 1) begin : g_bad_width
         $error("slot_tracker: RES_W must be at least 1");
      end
   endgenerate

   logic [NUM_SLOTS-1:0] trig_all;
   logic [NUM_SLOTS-1:0] done_hit;
   logic [NUM_SLOTS-1:0] ack_hit;
   logic [NUM_SLOTS-1:0] dben_v;
   logic [NUM_SLOTS-1:0] valid_v;
   logic [NUM_SLOTS-1:0] ovr_v;

   assign trig_all = hw_trig | (sw_trig_we ? sw_trig_mask : '0);

   slot_pend #(.NUM_SLOTS(NUM_SLOTS)) u_pend (
      .clk        (clk),
      .rst_n      (rst_n),
      .trig       (trig_all),
      .cancel_we  (cancel_we),
      .cancel_mask(cancel_mask),
      .done_hit   (done_hit),
      .clr_we     (tovf_clr_we),
      .clr_mask   (tovf_clr_mask),
      .pend_q     (pending),
      .tovf_q     (trig_ovf)
   );

   generate
      for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
         logic [WW-1:0]  word_s;
         logic [SW2-1:0] sec_s;

         assign done_hit[s] = eoc_valid && (eoc_slot == SLW'(s));
         assign ack_hit[s]  = ack_valid && (ack_slot == SLW'(s));

         if (s < NUM_DBUF) begin : g_two
            assign dben_v[s] = dbuf_en[s];
            assign dbuf_word[s*SW2 +: SW2] = sec_s;
         end else begin : g_one
            logic [SW2-1:0] unused_sec;
            assign dben_v[s]  = 1'b0;
            assign unused_sec = sec_s;
         end

         slot_result #(.RES_W(RES_W), .HAS_SECOND(s < NUM_DBUF)) u_res (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr     (done_hit[s]),
            .wr_data(eoc_data),
            .ack    (ack_hit[s]),
            .dben   (dben_v[s]),
            .word_o (word_s),
            .sec_o  (sec_s)
         );

         assign slot_word[s*WW +: WW] = word_s;
         assign valid_v[s] = word_s[RES_W + VAL_OFS];
         assign ovr_v[s]   = word_s[RES_W + OVR_OFS];
      end
   endgenerate

   assign busy      = |pending;
   assign any_valid = |valid_v;
   assign any_dovr  = |ovr_v;
   assign any_tovr  = |trig_ovf;

   AST_IDLE_WHEN_NOTHING_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !(|trig_all)) |=> (pending == '0 || $past(|trig_all))); // R9

endmodule

// File: tb/slot_tracker_test.sv
module slot_tracker_test;
   localparam int N   = 19;
   localparam int W   = 16;
   localparam int D   = 4;
   localparam int SLW = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic           sw_trig_we = 0, cancel_we = 0, eoc_valid = 0, ack_valid = 0, tovf_clr_we = 0;
   logic [N-1:0]   sw_trig_mask = '0, hw_trig = '0, cancel_mask = '0, tovf_clr_mask = '0;
   logic [SLW-1:0] eoc_slot = '0, ack_slot = '0;
   logic [W-1:0]   eoc_data = '0;
   logic [D-1:0]   dbuf_en = '0;
   logic [N-1:0]   pending, trig_ovf;
   logic [N*(W+2)-1:0] slot_word;
   logic [D*(W+1)-1:0] dbuf_word;
   logic busy, any_valid, any_dovr, any_tovr;

   slot_tracker #(.NUM_SLOTS(N), .RES_W(W), .NUM_DBUF(D)) uut (
      .clk(clk), .rst_n(rst_n), .sw_trig_we(sw_trig_we), .sw_trig_mask(sw_trig_mask),
      .hw_trig(hw_trig), .cancel_we(cancel_we), .cancel_mask(cancel_mask),
      .eoc_valid(eoc_valid), .eoc_slot(eoc_slot), .eoc_data(eoc_data),
      .ack_valid(ack_valid), .ack_slot(ack_slot), .dbuf_en(dbuf_en),
      .tovf_clr_we(tovf_clr_we), .tovf_clr_mask(tovf_clr_mask),
      .pending(pending), .trig_ovf(trig_ovf), .slot_word(slot_word), .dbuf_word(dbuf_word),
      .busy(busy), .any_valid(any_valid), .any_dovr(any_dovr), .any_tovr(any_tovr));

   typedef struct {
      int          kind;
      int          idx;
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t q[$];
   int tests = 0;
   int fails = 0;
   bit done = 0;

   // reference state built from the requirements
   logic [N-1:0] m_pend = '0, m_tovf = '0;
   logic         m_val[N], m_ovr[N], m_sval[D];
   logic [W-1:0] m_dat[N], m_sdat[D];

   task automatic push_all(input string tag);
      logic av, ao;
      av = 0; ao = 0;
      for (int s = 0; s < N; s++) begin
         av |= m_val[s]; ao |= m_ovr[s];
      end
      q.push_back('{0, 0, 32'(m_pend), tag});
      q.push_back('{1, 0, 32'(m_tovf), tag});
      q.push_back('{2, 0, {28'd0, |m_pend, av, ao, |m_tovf}, tag});
      for (int s = 0; s < N; s++) q.push_back('{3, s, {14'd0, m_val[s], m_ovr[s], m_dat[s]}, tag});
      for (int s = 0; s < D; s++) q.push_back('{4, s, {15'd0, m_sval[s], m_sdat[s]}, tag});
   endtask

   task automatic step(input string tag, input logic [N-1:0] swm, input logic [N-1:0] hwm,
                       input logic [N-1:0] cm, input logic ev, input int es, input logic [W-1:0] ed,
                       input logic av, input int asl, input logic [N-1:0] km);
      logic [N-1:0] t, eh;
      @(negedge clk);
      sw_trig_we = |swm; sw_trig_mask = swm; hw_trig = hwm;
      cancel_we = |cm; cancel_mask = cm;
      eoc_valid = ev; eoc_slot = es[SLW-1:0]; eoc_data = ed;
      ack_valid = av; ack_slot = asl[SLW-1:0];
      tovf_clr_we = |km; tovf_clr_mask = km;
      t = swm | hwm;
      eh = '0;
      if (ev && es < N) eh[es] = 1'b1;
      m_tovf = (m_tovf & ~km) | (t & m_pend);
      m_pend = (m_pend & ~cm & ~eh) | t;
      if (av && asl < N) begin
         m_val[asl] = 0; m_ovr[asl] = 0;
         if (asl < D) m_sval[asl] = 0;
      end
      if (ev && es < N) begin
         if (es < D && dbuf_en[es]) begin
            if (!m_val[es]) begin m_dat[es] = ed; m_val[es] = 1; end
            else if (!m_sval[es]) begin m_sdat[es] = ed; m_sval[es] = 1; end
            else begin m_sdat[es] = ed; m_ovr[es] = 1; end
         end else begin
            if (m_val[es]) m_ovr[es] = 1;
            m_dat[es] = ed; m_val[es] = 1;
         end
      end
      @(posedge clk);
      #1;
      sw_trig_we = 0; hw_trig = '0; cancel_we = 0; eoc_valid = 0; ack_valid = 0; tovf_clr_we = 0;
      push_all(tag);
   endtask

   // monitor: compares queued expectations against the ports after each edge
   initial begin
      forever begin
         @(posedge clk);
         #3;
         while (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = q.pop_front();
            case (it.kind)
               0: act = 32'(pending);
               1: act = 32'(trig_ovf);
               2: act = {28'd0, busy, any_valid, any_dovr, any_tovr};
               3: act = 32'(slot_word[it.idx*(W+2) +: (W+2)]);
               default: act = 32'(dbuf_word[it.idx*(W+1) +: (W+1)]);
            endcase
            tests++;
            if (act !== it.exp) begin
               fails++;
               $display("FAIL %s kind %0d idx %0d actual %h expected %h", it.tag, it.kind, it.idx, act, it.exp);
            end
         end
      end
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 100000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      for (int s = 0; s < N; s++) begin m_val[s] = 0; m_ovr[s] = 0; m_dat[s] = '0; end
      for (int s = 0; s < D; s++) begin m_sval[s] = 0; m_sdat[s] = '0; end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      push_all("R9 reset");
      // R1 software mask on slots 0, 2, 18
      step("R1 sw mask", 19'h40005, '0, '0, 0, 0, '0, 0, 0, '0);
      step("R1 hw pulse", '0, 19'h00080, '0, 0, 0, '0, 0, 0, '0);
      // R7 re-arm slot 2 while pending
      step("R7 retrigger", 19'h00004, '0, '0, 0, 0, '0, 0, 0, '0);
      // R7 clear slot 2 while slot 0 overruns; slot 0 clear collides with new overrun
      step("R7 clear vs set", 19'h00001, '0, '0, 0, 0, '0, 0, 0, 19'h00005);
      step("R3 cancel", '0, '0, 19'h40000, 0, 0, '0, 0, 0, '0);
      step("R2 R4 complete", '0, '0, '0, 1, 2, 16'hA5A5, 0, 0, '0);
      step("R4 store", '0, '0, '0, 1, 7, 16'h1234, 0, 0, '0);
      step("R6 R8 overrun", '0, '0, '0, 1, 7, 16'h5678, 0, 0, '0);
      step("R5 ack", '0, '0, '0, 0, 0, '0, 1, 7, '0);
      step("R2 out of range", '0, '0, '0, 1, 25, 16'hDEAD, 0, 0, '0);
      dbuf_en = 4'b0010;
      step("R10 first", '0, '0, '0, 1, 1, 16'h1111, 0, 0, '0);
      step("R10 second", '0, '0, '0, 1, 1, 16'h2222, 0, 0, '0);
      step("R10 third", '0, '0, '0, 1, 1, 16'h3333, 0, 0, '0);
      step("R5 ack two-deep", '0, '0, '0, 0, 0, '0, 1, 1, '0);
      step("R6 slot0 single a", '0, '0, '0, 1, 0, 16'h0F0F, 0, 0, '0);
      step("R6 slot0 single b", '0, '0, '0, 1, 0, 16'hF0F0, 0, 0, '0);
      step("R1 trig beats cancel", '0, 19'h00020, 19'h00020, 0, 0, '0, 0, 0, '0);
      step("R9 cancel all", '0, '0, 19'h7FFFF, 0, 0, '0, 0, 0, '0);
      step("R8 clear flags", '0, '0, '0, 0, 0, '0, 1, 0, 19'h7FFFF);
      step("R8 drain", '0, '0, '0, 0, 0, '0, 1, 2, '0);
      repeat (3) @(posedge clk);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule